// File: doc/BRIEF.md
# Shifter Operand Generator

This block forms the second source operand of a 32-bit data-processing instruction, together with the carry that the shifter hands on to the flag logic. It takes the instruction word, the value read for the operand register, the low byte of the shift-amount register, the current carry flag and a two-bit form select. From these it returns either a rotated 8-bit constant or the operand register moved by one of four shift kinds. The shift amount comes either from a 5-bit field of the instruction or from the register byte. The ALU, the register file, condition testing and flag writeback all sit outside this block.

Each shift kind has its own rules for the boundary amounts. A zero immediate amount stands for a full-width shift or for a one-bit rotate through the carry. Large register amounts saturate, and register rotates wrap modulo 32. When the operand or amount register is the program counter, register-shift form sees it four higher. The default build registers the result behind a one-cycle valid handshake. With `REGISTERED = 0` the block becomes purely combinational.

Top module: `shifter_operand_gen`

## Requirements
- R1: Form select 0 (rotated constant): the result is instr[7:0] rotated right by twice instr[11:8]. The carry out is result bit 31 when instr[11:8] is nonzero, and carry_in when it is zero.
- R2: Form select 1 (immediate shift): instr[6:5] picks the kind (0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right) and instr[11:7] gives the amount. The carry out is the last bit shifted out. A left shift by 0 returns the operand unchanged with carry_in.
- R3: In form 1, an amount of 0 with right logical or right arithmetic shifts by 32. An amount of 0 with rotate gives a one-bit rotate through the carry: the result is {carry_in, rm[31:1]} and the carry out is rm[0].
- R4: Form select 2 (register shift) takes its amount from the 8-bit rs_low. An amount of 0 returns the operand unchanged with carry_in, for every kind. Amounts from 1 to 31 shift normally.
- R5: In form 2, a left or right logical shift by exactly 32 gives zero, with carry rm[0] for left and rm[31] for right. Any amount of 33 or more gives zero with carry 0.
- R6: In form 2, a right arithmetic shift by 32 or more fills every result bit with rm[31], and the carry out is rm[31].
- R7: In form 2, a rotate by a nonzero amount whose low five bits are zero returns rm unchanged with carry rm[31]. Any other nonzero amount rotates by its low five bits.
- R8: In form 2 only, pc_is_rm adds 4 to the operand value (32-bit wrap) and pc_is_rs adds 4 to the amount byte (8-bit wrap). These flags have no effect in the other forms.
- R9: Form select 3 returns rm unchanged with carry_in.
- R10: Reset clears valid_out, operand_out and carry_out. A result appears one clock after valid_in is sampled high. When valid_in is low, valid_out drops and the previous operand and carry are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used when registered) |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_in | input | 1 | Inputs carry a request this cycle |
| form_sel | input | 2 | Operand form: 0 constant, 1 immediate shift, 2 register shift, 3 pass |
| instr | input | 32 | Instruction word; bits 11:0 are decoded |
| rm_val | input | 32 | Value read for the operand register |
| rs_low | input | 8 | Low byte of the amount register |
| pc_is_rm | input | 1 | Operand register is the program counter |
| pc_is_rs | input | 1 | Amount register is the program counter |
| carry_in | input | 1 | Current carry flag |
| valid_out | output | 1 | operand_out and carry_out hold a new result |
| operand_out | output | 32 | Shifter operand |
| carry_out | output | 1 | Shifter carry out |

## Verification
In the registered build, a request driven at a falling edge is captured at the next rising edge, so operand_out, carry_out and valid_out are due exactly one cycle later. The bench samples them at the following falling edge, before it drives anything new. The hold check lowers valid_in for one cycle and reads the outputs at the next falling edge. This confirms that the earlier result stayed in place while valid_out dropped. The reference model applies one-bit steps repeated as many times as the raw amount, so the saturation and wrap rules of the design are checked against plain repeated shifting.

// File: rtl/shop_pkg.sv
package shop_pkg;

    localparam int OP_W   = 32;
    localparam int AMT_W  = 6;
    localparam int IMM8_W = 8;
    localparam int WIDE_W = 2 * OP_W + 1;

    localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(OP_W);
    localparam logic [AMT_W-1:0] AMT_OVER = AMT_W'(OP_W + 1);

    typedef enum logic [1:0] {
        FORM_ROT_IMM   = 2'd0,
        FORM_IMM_SHIFT = 2'd1,
        FORM_REG_SHIFT = 2'd2,
        FORM_PASS      = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        TY_LSL = 2'd0,
        TY_LSR = 2'd1,
        TY_ASR = 2'd2,
        TY_ROR = 2'd3
    } shift_type_e;

    typedef enum logic [2:0] {
        SK_PASS,
        SK_LSL,
        SK_LSR,
        SK_ASR,
        SK_ROR,
        SK_RRX
    } shift_kind_e;

    typedef struct packed {
        shift_kind_e       kind;
        logic [AMT_W-1:0]  amount;
        logic [OP_W-1:0]   value;
    } shift_req_t;

    typedef struct packed {
        logic              valid;
        logic [OP_W-1:0]   operand;
        logic              carry;
    } shop_out_t;

endpackage

// File: rtl/shop_decode.sv
module shop_decode
    import shop_pkg::*;
(
    input  logic [1:0]      form_sel,
    input  logic [OP_W-1:0] instr,
    input  logic [OP_W-1:0] rm_val,
    input  logic [7:0]      rs_low,
    input  logic            pc_is_rm,
    input  logic            pc_is_rs,
    output shift_req_t      req
);

    logic [OP_W-1:0] rm_eff;
    logic [7:0]      rs_eff;
    logic [3:0]      rot_field;
    logic [4:0]      imm_amt;
    shift_type_e     sh_type;
    form_e           form;

    assign form      = form_e'(form_sel);
    assign rot_field = instr[11:8];
    assign imm_amt   = instr[11:7];
    assign sh_type   = shift_type_e'(instr[6:5]);

    // Program-counter reads are four higher only in register-shift form
    assign rm_eff = (form == FORM_REG_SHIFT && pc_is_rm) ? rm_val + OP_W'(4) : rm_val;
    assign rs_eff = (form == FORM_REG_SHIFT && pc_is_rs) ? rs_low + 8'd4 : rs_low;

    always_comb begin
        req.kind   = SK_PASS;
        req.amount = '0;
        req.value  = rm_eff;
        unique case (form)
            FORM_ROT_IMM: begin
                req.value = {{(OP_W-IMM8_W){1'b0}}, instr[IMM8_W-1:0]};
                if (rot_field != 4'd0) begin
                    req.kind   = SK_ROR;
                    req.amount = {1'b0, rot_field, 1'b0};
                end
            end
            FORM_IMM_SHIFT: begin
                unique case (sh_type)
                    TY_LSL: begin
                        if (imm_amt != 5'd0) begin
                            req.kind   = SK_LSL;
                            req.amount = {1'b0, imm_amt};
                        end
                    end
                    TY_LSR: begin
                        req.kind   = SK_LSR;
                        req.amount = (imm_amt == 5'd0) ? AMT_FULL : {1'b0, imm_amt};
                    end
                    TY_ASR: begin
                        req.kind   = SK_ASR;
                        req.amount = (imm_amt == 5'd0) ? AMT_FULL : {1'b0, imm_amt};
                    end
                    default: begin
                        if (imm_amt == 5'd0) begin
                            req.kind = SK_RRX;
                        end else begin
                            req.kind   = SK_ROR;
                            req.amount = {1'b0, imm_amt};
                        end
                    end
                endcase
            end
            FORM_REG_SHIFT: begin
                if (rs_eff != 8'd0) begin
                    unique case (sh_type)
                        TY_LSL: begin
                            req.kind   = SK_LSL;
                            req.amount = (rs_eff >= 8'd33) ? AMT_OVER : rs_eff[AMT_W-1:0];
                        end
                        TY_LSR: begin
                            req.kind   = SK_LSR;
                            req.amount = (rs_eff >= 8'd33) ? AMT_OVER : rs_eff[AMT_W-1:0];
                        end
                        TY_ASR: begin
                            req.kind   = SK_ASR;
                            req.amount = (rs_eff >= 8'd32) ? AMT_FULL : rs_eff[AMT_W-1:0];
                        end
                        default: begin
                            req.kind   = SK_ROR;
                            req.amount = (rs_eff[4:0] == 5'd0) ? AMT_FULL : {1'b0, rs_eff[4:0]};
                        end
                    endcase
                end
            end
            default: begin
                req.value = rm_val;
            end
        endcase
    end

endmodule

// File: rtl/shop_barrel.sv
module shop_barrel
    import shop_pkg::*;
(
    input  shift_req_t      req,
    input  logic            carry_in,
    output logic [OP_W-1:0] result,
    output logic            carry_out
);

    logic [WIDE_W-1:0]        wide_l;
    logic [WIDE_W-1:0]        wide_r;
    logic signed [WIDE_W-1:0] wide_a;
    logic [OP_W-1:0]          rot;
    logic [AMT_W-1:0]         rot_back;

    // Left: operand in the low half, carry lands at bit OP_W
    assign wide_l   = {{(OP_W+1){1'b0}}, req.value} << req.amount;
    // Right: operand in the high half, carry lands at bit OP_W
    assign wide_r   = {req.value, {(OP_W+1){1'b0}}} >> req.amount;
    assign wide_a   = $signed({req.value, {(OP_W+1){1'b0}}}) >>> req.amount;
    assign rot_back = AMT_FULL - req.amount;
    assign rot      = (req.value >> req.amount) | (req.value << rot_back);

    always_comb begin
        result    = req.value;
        carry_out = carry_in;
        unique case (req.kind)
            SK_LSL: begin
                result    = wide_l[OP_W-1:0];
                carry_out = wide_l[OP_W];
            end
            SK_LSR: begin
                result    = wide_r[WIDE_W-1:OP_W+1];
                carry_out = wide_r[OP_W];
            end
            SK_ASR: begin
                result    = wide_a[WIDE_W-1:OP_W+1];
                carry_out = wide_a[OP_W];
            end
            SK_ROR: begin
                result    = rot;
                carry_out = rot[OP_W-1];
            end
            SK_RRX: begin
                result    = {carry_in, req.value[OP_W-1:1]};
                carry_out = req.value[0];
            end
            default: begin
                result    = req.value;
                carry_out = carry_in;
            end
        endcase
    end

endmodule

// File: rtl/shifter_operand_gen.sv
module shifter_operand_gen
    import shop_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_in,
    input  logic [1:0]      form_sel,
    input  logic [31:0]     instr,
    input  logic [31:0]     rm_val,
    input  logic [7:0]      rs_low,
    input  logic            pc_is_rm,
    input  logic            pc_is_rs,
    input  logic            carry_in,
    output logic            valid_out,
    output logic [31:0]     operand_out,
    output logic            carry_out
);

    shift_req_t      req;
    logic [OP_W-1:0] sh_result;
    logic            sh_carry;

    shop_decode u_decode (
        .form_sel (form_sel),
        .instr    (instr),
        .rm_val   (rm_val),
        .rs_low   (rs_low),
        .pc_is_rm (pc_is_rm),
        .pc_is_rs (pc_is_rs),
        .req      (req)
    );

    shop_barrel u_barrel (
        .req       (req),
        .carry_in  (carry_in),
        .result    (sh_result),
        .carry_out (sh_carry)
    );

    generate
        if (REGISTERED) begin : g_reg
            shop_out_t out_d;
            shop_out_t out_q;

            always_comb begin
                out_d       = out_q;
                out_d.valid = valid_in;
                if (valid_in) begin
                    out_d.operand = sh_result;
                    out_d.carry   = sh_carry;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= out_d;
            end

            assign valid_out   = out_q.valid;
            assign operand_out = out_q.operand;
            assign carry_out   = out_q.carry;

            // R10
            valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
                valid_in |=> valid_out);

            // R10
            hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !valid_in |=> (!valid_out && $stable(operand_out) && $stable(carry_out)));

            // R1
            rot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_in && form_sel == 2'd0 && instr[11:8] == 4'd0)
                |=> (operand_out == {24'd0, $past(instr[7:0])} && carry_out == $past(carry_in)));

            // R3
            asr_imm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_in && form_sel == 2'd1 && instr[6:5] == 2'd2 && instr[11:7] == 5'd0)
                |=> (operand_out == {32{$past(rm_val[31])}} && carry_out == $past(rm_val[31])));

            // R5
            lsl_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_in && form_sel == 2'd2 && instr[6:5] == 2'd0 && !pc_is_rs && rs_low >= 8'd33)
                |=> (operand_out == 32'd0 && !carry_out));

            // R9
            pass_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_in && form_sel == 2'd3)
                |=> (operand_out == $past(rm_val) && carry_out == $past(carry_in)));
        end else begin : g_comb
            assign valid_out   = valid_in;
            assign operand_out = sh_result;
            assign carry_out   = sh_carry;
        end
    endgenerate

endmodule

// File: tb/shifter_operand_gen_tb.sv
`timescale 1ns/1ps
module shifter_operand_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [1:0]  form_sel = 2'd0;
    logic [31:0] instr = 32'd0;
    logic [31:0] rm_val = 32'd0;
    logic [7:0]  rs_low = 8'd0;
    logic        pc_is_rm = 1'b0;
    logic        pc_is_rs = 1'b0;
    logic        carry_in = 1'b0;
    logic        valid_out;
    logic [31:0] operand_out;
    logic        carry_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    shifter_operand_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_in    (valid_in),
        .form_sel    (form_sel),
        .instr       (instr),
        .rm_val      (rm_val),
        .rs_low      (rs_low),
        .pc_is_rm    (pc_is_rm),
        .pc_is_rs    (pc_is_rs),
        .carry_in    (carry_in),
        .valid_out   (valid_out),
        .operand_out (operand_out),
        .carry_out   (carry_out)
    );

    // One-bit step of a shift kind; returns {carry, value}
    function automatic logic [32:0] step(input logic [1:0] ty, input logic [31:0] v);
        case (ty)
            2'd0:    return {v[31], v[30:0], 1'b0};
            2'd1:    return {v[0], 1'b0, v[31:1]};
            2'd2:    return {v[0], v[31], v[31:1]};
            default: return {v[0], v[0], v[31:1]};
        endcase
    endfunction

    function automatic logic [32:0] model(input logic [1:0] f, input logic [31:0] ins,
                                          input logic [31:0] rm, input logic [7:0] rs,
                                          input logic prm, input logic prs, input logic cin);
        logic [32:0] cv;
        logic [1:0]  ty;
        int          n;
        logic [7:0]  a;
        cv = {cin, rm};
        ty = ins[6:5];
        case (f)
            2'd0: begin
                cv = {cin, 24'd0, ins[7:0]};
                n  = 2 * int'(ins[11:8]);
                for (int i = 0; i < n; i++) cv = step(2'd3, cv[31:0]);
            end
            2'd1: begin
                n = int'(ins[11:7]);
                if (ty == 2'd3 && n == 0) begin
                    cv = {rm[0], cin, rm[31:1]};
                end else begin
                    if ((ty == 2'd1 || ty == 2'd2) && n == 0) n = 32;
                    for (int i = 0; i < n; i++) cv = step(ty, cv[31:0]);
                end
            end
            2'd2: begin
                cv = {cin, prm ? rm + 32'd4 : rm};
                a  = prs ? rs + 8'd4 : rs;
                for (int i = 0; i < int'(a); i++) cv = step(ty, cv[31:0]);
            end
            default: cv = {cin, rm};
        endcase
        return cv;
    endfunction

    task automatic check(input string tag, input logic exp_valid,
                         input logic [31:0] exp_v, input logic exp_c);
        n_tests++;
        if (valid_out !== exp_valid || operand_out !== exp_v || carry_out !== exp_c) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b op=%08h c=%0b, expected valid=%0b op=%08h c=%0b",
                     tag, valid_out, operand_out, carry_out, exp_valid, exp_v, exp_c);
        end
    endtask

    task automatic run_vec(input string tag, input logic [1:0] f, input logic [31:0] ins,
                           input logic [31:0] rm, input logic [7:0] rs,
                           input logic prm, input logic prs, input logic cin);
        logic [32:0] e;
        @(negedge clk);
        valid_in = 1'b1; form_sel = f; instr = ins; rm_val = rm; rs_low = rs;
        pc_is_rm = prm; pc_is_rs = prs; carry_in = cin;
        e = model(f, ins, rm, rs, prm, prs, cin);
        @(negedge clk);
        check(tag, 1'b1, e[31:0], e[32]);
    endtask

    function automatic logic [31:0] pat(input int k);
        case (k)
            0:       return 32'h8000_0001;
            1:       return 32'h7FFF_FFFE;
            2:       return 32'hA5C3_0F96;
            default: return 32'h0000_0000;
        endcase
    endfunction

    initial begin
        logic [32:0] keep;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset", 1'b0, 32'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", 1'b0, 32'd0, 1'b0);

        // R1: rotated constant, every rotate field
        for (int r = 0; r < 16; r++)
            for (int k = 0; k < 4; k++)
                for (int c = 0; c < 2; c++) begin
                    logic [7:0] imm;
                    imm = (k == 0) ? 8'h01 : (k == 1) ? 8'h80 : (k == 2) ? 8'hA7 : 8'h00;
                    run_vec("R1", 2'd0, {20'd0, 4'(r), imm}, 32'hDEAD_BEEF, 8'd0, 1'b1, 1'b1, c[0]);
                end

        // R2 / R3: immediate shift, all kinds and amounts
        for (int t = 0; t < 4; t++)
            for (int s = 0; s < 32; s++)
                for (int k = 0; k < 4; k++)
                    for (int c = 0; c < 2; c++)
                        run_vec((s == 0 && t != 0) ? "R3" : "R2", 2'd1,
                                {20'd0, 5'(s), 2'(t), 1'b0, 4'd0}, pat(k), 8'hFF, 1'b0, 1'b0, c[0]);

        // R4..R7: register shift, every amount byte
        for (int t = 0; t < 4; t++)
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 4; k++)
                    for (int c = 0; c < 2; c++) begin
                        string tg;
                        if (a == 0)                 tg = "R4";
                        else if (t == 3)            tg = "R7";
                        else if (t == 2 && a >= 32) tg = "R6";
                        else if (t < 2 && a >= 32)  tg = "R5";
                        else                        tg = "R4";
                        run_vec(tg, 2'd2, {20'd0, 4'd3, 1'b0, 2'(t), 1'b1, 4'd2},
                                pat(k), 8'(a), 1'b0, 1'b0, c[0]);
                    end

        // R8: program-counter adjust in register form
        for (int t = 0; t < 4; t++)
            for (int a = 0; a < 40; a++) begin
                run_vec("R8 rm", 2'd2, {20'd0, 4'd15, 1'b0, 2'(t), 1'b1, 4'd15},
                        32'hFFFF_FFFE, 8'(a), 1'b1, 1'b0, 1'b1);
                run_vec("R8 rs", 2'd2, {20'd0, 4'd15, 1'b0, 2'(t), 1'b1, 4'd1},
                        32'h9000_0003, 8'(a + 220), 1'b0, 1'b1, 1'b0);
            end
        // R8: flags ignored outside register form
        run_vec("R8 imm-shift", 2'd1, {20'd0, 5'd4, 2'd1, 1'b0, 4'd15},
                32'h0000_1000, 8'd0, 1'b1, 1'b1, 1'b0);
        run_vec("R8 pass", 2'd3, 32'd0, 32'h1234_5678, 8'd0, 1'b1, 1'b1, 1'b0);

        // R9: pass form
        for (int k = 0; k < 4; k++)
            for (int c = 0; c < 2; c++)
                run_vec("R9", 2'd3, 32'hFFFF_FFFF, pat(k), 8'd7, 1'b0, 1'b0, c[0]);

        // R10: hold when valid_in is low
        run_vec("R10 load", 2'd2, {20'd0, 4'd3, 1'b0, 2'd2, 1'b1, 4'd2},
                32'h8000_0000, 8'd4, 1'b0, 1'b0, 1'b0);
        keep = {1'b0, 32'hF800_0000};
        @(negedge clk);
        valid_in = 1'b0; rm_val = 32'h0000_00FF; form_sel = 2'd3; carry_in = 1'b1;
        @(negedge clk);
        check("R10 hold", 1'b0, keep[31:0], keep[32]);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule